// File: doc/BRIEF.md
# Temperature Bin Indexer With Hysteresis

This block turns periodic signed temperature readings into a table index that a downstream look-up table uses to pick a setting for each controlled output. Each index covers a two-degree slice of the working range. Near every slice edge there is a one-degree dead band, so a reading that wanders around an edge does not make the index toggle. Readings outside the working range pin the index to the first or last slice.

Readings arrive as a 16-bit two's complement word in units of 1/256 °C, together with a valid strobe. The block takes one reading per frame. A frame tick arms a conversion, and the first valid reading on a cycle when the serial bus is idle is accepted. One conversion is armed by reset itself, so the first reading is taken without any tick. If a tick arrives while the bus is busy, it stays pending until the bus goes idle.

The accepted reading is published as a high byte and a low byte for the status register bank. A single-cycle pulse marks every accepted conversion that moved the index.

Top module: `temp_bin_indexer`

## Requirements
- R1: While reset is asserted and directly after it, `bin_idx` is 0, `temp_msb` and `temp_lsb` are 0 and `bin_changed` is 0.
- R2: After reset one conversion is already armed. The first cycle with `sample_valid` high and `bus_busy` low accepts the sample without any `frame_tick`.
- R3: Once a conversion has been accepted, further valid samples have no effect on any output until the next `frame_tick` arms another one.
- R4: No sample is accepted on a cycle with `bus_busy` high. A `frame_tick` seen while busy stays pending, and its sample is accepted on the first idle cycle with `sample_valid` high.
- R5: One clock after acceptance, `temp_msb` equals sample bits [15:8] (status address 60h) and `temp_lsb` equals bits [7:0] (address 61h).
- R6: With the sample read as T = sample/256 °C, the raw bin is floor((T + 40) / 2). On acceptance, a raw bin above the current index becomes the new index, so a rising reading moves up as soon as it reaches the slice's lower edge.
- R7: The index drops only when T + 1 lies in a lower bin. It then becomes floor((T + 1 + 40) / 2). A reading exactly 1 °C below the current slice's lower edge leaves the index unchanged.
- R8: A reading below -40 °C gives bin 0. A reading at or above +102 °C gives bin 70, the last of 71 bins.
- R9: `bin_changed` is high for exactly the one clock after an acceptance that changed `bin_idx`, and low otherwise. `bin_idx` is stable between acceptances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Frame period strobe, arms one conversion |
| bus_busy | input | 1 | Serial bus transfer in progress |
| sample_valid | input | 1 | Temperature sample present |
| sample | input | 16 | Signed temperature, 1/256 °C per LSB |
| bin_idx | output | 7 | Current table index |
| temp_msb | output | 8 | High byte of the latest accepted sample |
| temp_lsb | output | 8 | Low byte of the latest accepted sample |
| bin_changed | output | 1 | One-clock pulse when the index moved |

## Verification
The assertions check on every cycle that nothing changes while the bus is busy, that outputs change only after an acceptance, that the published bytes track the accepted sample, that the change pulse matches an index move, and that the index stays in range. Whether the index lands on the right bin is left to the bench scenarios. That covers rising and falling ramps in quarter-degree steps, exact edges one LSB apart, clamping far outside the range, and a pseudo-random spread of readings, all compared against an arithmetic model. The bench scenarios also cover the reset-armed first conversion, tick pending across a busy bus, and samples ignored without a tick.

// File: rtl/tbi_pkg.sv
package tbi_pkg;

   // Fixed-point scale of the temperature word
   localparam int TBI_FRAC = 8;

   // Outcome of one conversion for the index register
   typedef enum logic [1:0] {
      MV_HOLD = 2'd0,
      MV_UP   = 2'd1,
      MV_DOWN = 2'd2
   } tbi_move_e;

endpackage

// File: rtl/tbi_sched.sv
// Conversion scheduler: one armed request per frame, deferred while bus busy
module tbi_sched (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   input  logic bus_busy,
   input  logic sample_valid,
   output logic launch
);

   logic req_q;
   logic want;

   assign want   = req_q | frame_tick;
   assign launch = want & ~bus_busy & sample_valid;

   // Reset arms the first conversion
   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b1;
      else        req_q <= want & ~launch;
   end

   // R4: a tick seen during a bus transfer is kept pending
   a_r4_tick_kept_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && bus_busy) |=> req_q);

   // R3: an accepted conversion consumes the request unless a new tick arrives
   a_r3_request_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !frame_tick) |=> (!req_q || $past(frame_tick)) );

endmodule

// File: rtl/tbi_binner.sv
// Maps a fixed-point temperature (plus a constant offset) to a clamped bin
module tbi_binner #(
   parameter int TEMP_W   = 16,
   parameter int FRAC     = 8,
   parameter int T_MIN    = -40,
   parameter int BIN_DEG  = 2,
   parameter int NUM_BINS = 71,
   parameter int ADD_DEG  = 0,
   parameter int IDX_W    = 7
) (
   input  logic [TEMP_W-1:0] temp,
   output logic [IDX_W-1:0]  bin
);

   localparam int OW = TEMP_W + 2;
   localparam int SH = FRAC + $clog2(BIN_DEG);
   localparam logic signed [OW-1:0] BIAS = OW'((ADD_DEG - T_MIN) * (2 ** FRAC));
   localparam logic signed [OW-1:0] LAST = OW'(NUM_BINS - 1);

   logic signed [OW-1:0] off;
   logic signed [OW-1:0] slot;

   assign off  = $signed({{2{temp[TEMP_W-1]}}, temp}) + BIAS;
   assign slot = off >>> SH;

   always_comb begin
      if (off[OW-1])       bin = '0;
      else if (slot > LAST) bin = IDX_W'(NUM_BINS - 1);
      else                 bin = slot[IDX_W-1:0];
   end

endmodule

// File: rtl/temp_bin_indexer.sv
module temp_bin_indexer
   import tbi_pkg::*;
#(
   parameter int TEMP_W   = 16,
   parameter int T_MIN    = -40,
   parameter int T_MAX    = 102,
   parameter int BIN_DEG  = 2,
   parameter int HYST_DEG = 1,
   localparam int NUM_BINS = (T_MAX - T_MIN) / BIN_DEG,
   localparam int IDX_W    = $clog2(NUM_BINS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              bus_busy,
   input  logic              sample_valid,
   input  logic [TEMP_W-1:0] sample,
   output logic [IDX_W-1:0]  bin_idx,
   output logic [7:0]        temp_msb,
   output logic [7:0]        temp_lsb,
   output logic              bin_changed
);

   // Elaboration-time parameter checks
   if (TEMP_W != 16) begin : g_bad_width
      $error("temp_bin_indexer: TEMP_W must be 16 (two status bytes)");
   end
   if (T_MAX <= T_MIN) begin : g_bad_range
      $error("temp_bin_indexer: T_MAX must exceed T_MIN");
   end
   if ((BIN_DEG & (BIN_DEG - 1)) != 0 || BIN_DEG < 1) begin : g_bad_bin
      $error("temp_bin_indexer: BIN_DEG must be a power of two");
   end
   if (HYST_DEG < 0 || HYST_DEG >= BIN_DEG) begin : g_bad_hyst
      $error("temp_bin_indexer: HYST_DEG must lie in [0, BIN_DEG)");
   end

   logic              launch;
   logic [IDX_W-1:0]  raw_bin;
   logic [IDX_W-1:0]  dn_bin;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  idx_nxt;
   logic [TEMP_W-1:0] temp_q;
   logic              chg_q;
   tbi_move_e         move;

   tbi_sched u_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_tick   (frame_tick),
      .bus_busy     (bus_busy),
      .sample_valid (sample_valid),
      .launch       (launch)
   );

   tbi_binner #(
      .TEMP_W(TEMP_W), .FRAC(TBI_FRAC), .T_MIN(T_MIN), .BIN_DEG(BIN_DEG),
      .NUM_BINS(NUM_BINS), .ADD_DEG(0), .IDX_W(IDX_W)
   ) u_raw (
      .temp (sample),
      .bin  (raw_bin)
   );

   // Falling threshold: bin of the reading lifted by the hysteresis band
   if (HYST_DEG > 0) begin : g_hyst
      tbi_binner #(
         .TEMP_W(TEMP_W), .FRAC(TBI_FRAC), .T_MIN(T_MIN), .BIN_DEG(BIN_DEG),
         .NUM_BINS(NUM_BINS), .ADD_DEG(HYST_DEG), .IDX_W(IDX_W)
      ) u_dn (
         .temp (sample),
         .bin  (dn_bin)
      );
   end else begin : g_plain
      assign dn_bin = raw_bin;
   end

   always_comb begin
      if (raw_bin > idx_q)     move = MV_UP;
      else if (dn_bin < idx_q) move = MV_DOWN;
      else                     move = MV_HOLD;
      unique case (move)
         MV_UP:   idx_nxt = raw_bin;
         MV_DOWN: idx_nxt = dn_bin;
         default: idx_nxt = idx_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         temp_q <= '0;
         chg_q  <= 1'b0;
      end else if (launch) begin
         idx_q  <= idx_nxt;
         temp_q <= sample;
         chg_q  <= (move != MV_HOLD);
      end else begin
         chg_q  <= 1'b0;
      end
   end

   assign bin_idx     = idx_q;
   assign temp_msb    = temp_q[15:8];
   assign temp_lsb    = temp_q[7:0];
   assign bin_changed = chg_q;

   // R4: a busy bus freezes every result
   a_r4_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |=> ($stable(bin_idx) && $stable(temp_q) && !bin_changed));

   // R3 / R9: outputs move only after an accepted conversion
   a_r3_hold_without_launch: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> ($stable(bin_idx) && $stable(temp_q) && !bin_changed));

   // R5: status bytes follow the accepted sample
   a_r5_bytes_follow: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> ({temp_msb, temp_lsb} == $past(sample)));

   // R9: pulse coincides exactly with an index move
   a_r9_pulse_matches_move: assert property (@(posedge clk) disable iff (!rst_n)
      bin_changed == (bin_idx != $past(bin_idx)));

   // R8: index never leaves the table
   a_r8_index_in_table: assert property (@(posedge clk) disable iff (!rst_n)
      bin_idx <= IDX_W'(NUM_BINS - 1));

endmodule

// File: tb/temp_bin_indexer_test.sv
module temp_bin_indexer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_tick = 1'b0;
   logic        bus_busy = 1'b0;
   logic        sample_valid = 1'b0;
   logic [15:0] sample = '0;
   logic [6:0]  bin_idx;
   logic [7:0]  temp_msb;
   logic [7:0]  temp_lsb;
   logic        bin_changed;

   int errors = 0;
   int checks = 0;
   int ref_idx = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   temp_bin_indexer uut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .bus_busy(bus_busy),
      .sample_valid(sample_valid), .sample(sample), .bin_idx(bin_idx),
      .temp_msb(temp_msb), .temp_lsb(temp_lsb), .bin_changed(bin_changed)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Model: bin = floor((T+40)/2), clamped to 0..70, T in 1/256 degree units
   function automatic int model_bin(input int t);
      int off;
      off = t + 40 * 256;
      if (off < 0) return 0;
      if (off / 512 > 70) return 70;
      return off / 512;
   endfunction

   function automatic int model_next(input int cur, input int t);
      int up;
      int dn;
      up = model_bin(t);
      dn = model_bin(t + 256);
      if (up > cur) return up;
      if (dn < cur) return dn;
      return cur;
   endfunction

   // One framed conversion with the bus idle; checks R5..R9
   task automatic convert(input int t, input string req);
      int exp;
      @(negedge clk);
      sample = 16'(t);
      sample_valid = 1'b1;
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      sample_valid = 1'b0;
      exp = model_next(ref_idx, t);
      chk(int'(bin_idx) == exp, req, int'(bin_idx), exp);
      chk(bin_changed == (exp != ref_idx), "R9 pulse", int'(bin_changed), int'(exp != ref_idx));
      chk({temp_msb, temp_lsb} == 16'(t), "R5 bytes", int'({temp_msb, temp_lsb}), t & 16'hFFFF);
      ref_idx = exp;
      @(negedge clk);
      chk(bin_changed == 1'b0, "R9 one clock", int'(bin_changed), 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      int seed;
      int t;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(bin_idx == 0, "R1 idx", int'(bin_idx), 0);
      chk({temp_msb, temp_lsb} == 0, "R1 bytes", int'({temp_msb, temp_lsb}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bin_changed == 0 && bin_idx == 0, "R1 after release", int'(bin_idx), 0);

      // R2: first sample accepted with no tick (25 C -> bin 32)
      sample = 16'(25 * 256);
      sample_valid = 1'b1;
      @(negedge clk);
      chk(bin_idx == 32, "R2 armed by reset", int'(bin_idx), 32);
      chk(bin_changed == 1'b1, "R2 pulse", int'(bin_changed), 1);
      ref_idx = 32;

      // R3: further valid samples ignored without a tick
      sample = 16'(80 * 256);
      repeat (4) @(negedge clk);
      chk(bin_idx == 32, "R3 idx ignored", int'(bin_idx), 32);
      chk({temp_msb, temp_lsb} == 16'(25 * 256), "R3 bytes ignored",
          int'({temp_msb, temp_lsb}), 25 * 256);
      chk(bin_changed == 0, "R3 no pulse", int'(bin_changed), 0);

      // R4: tick during busy bus held pending
      bus_busy = 1'b1;
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      repeat (3) @(negedge clk);
      chk(bin_idx == 32, "R4 no accept while busy", int'(bin_idx), 32);
      bus_busy = 1'b0;
      @(negedge clk);
      chk(bin_idx == 60, "R4 serviced on first idle", int'(bin_idx), 60);
      chk(temp_msb == 8'd80, "R4 bytes", int'(temp_msb), 80);
      sample_valid = 1'b0;
      ref_idx = 60;

      // R7: exact falling edge at 30.0 C (bin 35)
      convert(30 * 256, "R6 set 30C");
      convert(29 * 256, "R7 exactly 1C below stays");
      convert(29 * 256 - 1, "R7 one LSB further drops");
      convert(30 * 256 - 1, "R6 below edge stays");
      convert(30 * 256, "R6 reaching edge rises");

      // R8: clamps
      convert(-100 * 256, "R8 low clamp");
      convert(-40 * 256, "R8 range floor");
      convert(102 * 256, "R8 high clamp at 102");
      convert(127 * 256, "R8 far above");

      // R6 rising ramp, then R7 falling ramp, quarter-degree steps
      for (int v = -44 * 256; v <= 104 * 256; v += 64) convert(v, "R6 rising ramp");
      for (int v = 104 * 256; v >= -44 * 256; v -= 64) convert(v, "R7 falling ramp");

      // R6/R7/R8: pseudo-random jumps across the full word
      seed = 32'h1234_5678;
      for (int k = 0; k < 300; k++) begin
         seed = seed * 1103515245 + 12345;
         t = int'($signed(16'(seed >>> 8)));
         convert(t, "R6 R7 R8 random");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule